// File: doc/BRIEF.md
# Buffered Full-Duplex Serial Port

This block is an asynchronous serial port for a small microcontroller subsystem. It has a two-word register window. Address 0 is a control and status word. Address 1 is a data word whose meaning depends on direction: a write hands a byte to the transmitter and starts a frame, and a read returns the last byte that was received. The transmitter's contents cannot be read back. Frames carry one start bit, then either 8 or 9 data bits sent least significant bit first, then one stop bit. The bit timing comes from an external oversampling strobe, `baud_tick`, which pulses 16 times per bit.

The receiver keeps the last completed byte in a holding latch. Its shifter can therefore take in the next frame while software has not yet read the previous one. A transmit-done flag and a receive-done flag together form one interrupt request. Hardware only ever sets these flags. Software clears each flag by writing 0 to its bit, so the handler can tell from the flags which event happened.

Top module: `sio_port`

## Requirements
- R1: After reset, `txd` is 1, `irq` is 0, and both the control word (address 0) and the data word (address 1) read 0.
- R2: A write to address 1 starts a frame. The frame is a start bit of 0, then the written byte LSB first, then, only when MODE9 (control bit 6) is 1, a ninth bit equal to TB8 (control bit 4), then a stop bit of 1. Each bit lasts 16 `baud_tick` pulses, and `txd` is 1 while idle.
- R3: TI (control bit 0) stays 0 while a frame is shifting out and becomes 1 once the stop bit has finished.
- R4: A read of address 1 returns the received-byte latch, never the byte last written for transmission.
- R5: Reception starts on a falling edge of the line, seen on a tick. The start bit must still read low at mid-bit, otherwise the receiver returns to idle. A low pulse shorter than half a bit therefore yields no byte. Each bit value is the majority of three ticks at the bit centre, so one wrong sample at the centre does not corrupt the bit.
- R6: When a frame completes, the byte goes into the latch and RI (control bit 1) becomes 1. RB8 (control bit 3, read-only) takes the received ninth bit in 9-bit mode and the stop bit in 8-bit mode.
- R7: Hardware never clears TI, RI or OVR (control bit 2). A write to address 0 clears each of these flags whose written bit is 0 and leaves each flag whose written bit is 1 unchanged. The same write loads TB8, REN (bit 5) and MODE9 from the written value. Bit 7 reads 0.
- R8: `irq` is 1 exactly when TI or RI is 1.
- R9: While RI is set, the latch keeps the previous byte until the next frame completes. A frame that completes while RI is still 1 overwrites the latch and sets OVR.
- R10: While REN is 0 the receive line is ignored: RI does not rise and the latch does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | Strobe at 16x the bit rate |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 1 | 0 = control/status, 1 = data |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| irq | output | 1 | Combined interrupt request |

## Verification
The transmitter is driven with bytes 0xA5, 0x00, 0xFF and 0x80, which separate bit-order mistakes, a stuck line and a missing start or stop bit. In 9-bit mode it sends 0xC3 with TB8 set and 0x81 with TB8 clear, which checks that the ninth bit follows TB8 rather than the data. The receiver gets clean frames, a frame with a single-sample glitch at a bit centre (majority vote), a short false start (mid-bit confirmation), and two frames without an RI clear in between (latch hold, then overrun). It also gets a frame while REN is 0. Reading back RB8 in both modes shows whether the ninth-bit capture or the stop-bit capture was selected.

// File: rtl/sio_port.sv
module sio_port #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic       reg_we,
  input  logic       reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       rxd,
  output logic       txd,
  output logic       irq
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);
  localparam logic [CW-1:0] MID  = CW'(OVS / 2 + 1);

  logic ti, ri, ovr, rb8, tb8, ren, mode9;
  logic [7:0] rx_buf;

  wire ctl_wr = reg_we & ~reg_addr;
  wire dat_wr = reg_we & reg_addr;

  // transmitter: stop bit is the highest 1, zero fill marks the end
  logic          tx_busy;
  logic [10:0]   tx_sr;
  logic [CW-1:0] tx_cnt;
  wire tx_bit_end = tx_busy & baud_tick & (tx_cnt == LAST);
  wire tx_done    = tx_bit_end & ~|tx_sr[10:1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_busy <= 1'b0;
      tx_sr   <= '0;
      tx_cnt  <= '0;
    end else if (dat_wr) begin
      tx_busy <= 1'b1;
      tx_sr   <= mode9 ? {1'b1, tb8, reg_wdata, 1'b0} : {2'b01, reg_wdata, 1'b0};
      tx_cnt  <= '0;
    end else if (tx_busy && baud_tick) begin
      tx_cnt <= (tx_cnt == LAST) ? '0 : tx_cnt + 1'b1;
      if (tx_done)         tx_busy <= 1'b0;
      else if (tx_bit_end) tx_sr   <= tx_sr >> 1;
    end
  end

  assign txd = ~tx_busy | tx_sr[0];

  // receiver
  logic          rx_m, rx_s, rx_last;
  logic [1:0]    hist;
  logic          rx_act;
  logic [CW-1:0] rx_cnt;
  logic [3:0]    rx_bit;
  logic [8:0]    rx_sr;

  wire       vote     = (hist[1] & hist[0]) | (hist[1] & rx_s) | (hist[0] & rx_s);
  wire [3:0] last_bit = mode9 ? 4'd10 : 4'd9;
  wire       rx_mid   = rx_act & ren & baud_tick & (rx_cnt == MID);
  wire       rx_done  = rx_mid & (rx_bit == last_bit);
  wire [8:0] rx_word  = mode9 ? rx_sr : {vote, rx_sr[8:1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_m    <= 1'b1;
      rx_s    <= 1'b1;
      rx_last <= 1'b1;
      hist    <= 2'b11;
      rx_act  <= 1'b0;
      rx_cnt  <= '0;
      rx_bit  <= '0;
      rx_sr   <= '0;
    end else begin
      rx_m <= rxd;
      rx_s <= rx_m;
      if (baud_tick) begin
        rx_last <= rx_s;
        hist    <= {hist[0], rx_s};
      end
      if (!ren) begin
        rx_act <= 1'b0;
      end else if (baud_tick) begin
        if (!rx_act) begin
          if (rx_last && !rx_s) begin
            rx_act <= 1'b1;
            rx_cnt <= '0;
            rx_bit <= '0;
          end
        end else begin
          rx_cnt <= (rx_cnt == LAST) ? '0 : rx_cnt + 1'b1;
          if (rx_cnt == MID) begin
            if ((rx_bit == 4'd0 && vote) || rx_bit == last_bit) begin
              rx_act <= 1'b0;
            end else begin
              if (rx_bit != 4'd0) rx_sr <= {vote, rx_sr[8:1]};
              rx_bit <= rx_bit + 1'b1;
            end
          end
        end
      end
    end
  end

  // control, flags and receive latch
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ti <= 1'b0; ri <= 1'b0; ovr <= 1'b0; rb8 <= 1'b0;
      tb8 <= 1'b0; ren <= 1'b0; mode9 <= 1'b0;
      rx_buf <= '0;
    end else begin
      ti  <= tx_done | (ti  & ~(ctl_wr & ~reg_wdata[0]));
      ri  <= rx_done | (ri  & ~(ctl_wr & ~reg_wdata[1]));
      ovr <= (rx_done & ri) | (ovr & ~(ctl_wr & ~reg_wdata[2]));
      if (rx_done) begin
        rx_buf <= rx_word[7:0];
        rb8    <= rx_word[8];
      end
      if (ctl_wr) begin
        tb8   <= reg_wdata[4];
        ren   <= reg_wdata[5];
        mode9 <= reg_wdata[6];
      end
    end
  end

  assign reg_rdata = reg_addr ? rx_buf : {1'b0, mode9, ren, tb8, rb8, ovr, ri, ti};
  assign irq = ti | ri;
endmodule

// File: rtl/sio_port_chk.sv
module sio_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_we,
  input logic       reg_addr,
  input logic [7:0] reg_wdata,
  input logic       txd,
  input logic       ti,
  input logic       ri,
  input logic       ovr,
  input logic       ren,
  input logic [7:0] rx_buf
);
  AST_TI_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ti && !(reg_we && !reg_addr && !reg_wdata[0]) |=> ti); // R7
  AST_RI_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ri && !(reg_we && !reg_addr && !reg_wdata[1]) |=> ri); // R7
  AST_TX_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && reg_addr |=> !txd); // R2
  AST_OVR_NEEDS_RI: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $past(ri)); // R9
  AST_RX_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !ren |=> !$rose(ri)); // R10
  AST_BUF_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_buf) |-> ri); // R6
endmodule

bind sio_port sio_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .txd(txd), .ti(ti), .ri(ri), .ovr(ovr),
  .ren(ren), .rx_buf(rx_buf)
);

// File: tb/sio_port_bench.sv
module sio_port_bench;
  localparam int BT = 48;

  logic clk = 1'b0, rst_n = 1'b0, baud_tick = 1'b0;
  logic reg_we = 1'b0, reg_addr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic rxd = 1'b1;
  logic txd, irq;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  logic [9:0] txq[$];
  logic [7:0] rxq[$];
  int tdiv = 0;

  sio_port u_sio_port (.*);

  always #10 clk = ~clk;

  always @(posedge clk) begin
    tdiv <= (tdiv == 2) ? 0 : tdiv + 1;
    baud_tick <= (tdiv == 2);
  end

  task automatic check(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(logic a, output logic [7:0] v);
    @(negedge clk); reg_addr = a; #1 v = reg_rdata;
  endtask

  task automatic tx_send(logic [7:0] d, logic m9, logic b8);
    txq.push_back({m9, b8, d});
    wr(1'b1, d);
  endtask

  task automatic rx_frame(logic [7:0] d, logic m9, logic b8, int gbit);
    logic [9:0] bits;
    int n;
    bits = {b8, d, 1'b0};
    n = m9 ? 10 : 9;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rxd = bits[i];
      if (i - 1 == gbit) begin
        repeat (22) @(negedge clk);
        rxd = ~bits[i];
        repeat (3) @(negedge clk);
        rxd = bits[i];
        repeat (22) @(negedge clk);
      end else begin
        repeat (BT - 1) @(negedge clk);
      end
    end
    @(negedge clk); rxd = 1'b1;
    repeat (BT + 4) @(negedge clk);
  endtask

  // monitor: decode txd and compare against the scoreboard queue
  initial begin : tx_mon
    logic [7:0] d;
    logic st, b9, sp;
    logic [9:0] e;
    forever begin
      @(negedge clk);
      if (txd === 1'b0 && rst_n) begin
        repeat (23) @(negedge clk);
        st = txd;
        for (int i = 0; i < 8; i++) begin
          repeat (BT) @(negedge clk);
          d[i] = txd;
        end
        if (txq.size() == 0) begin
          check("R2 unexpected tx frame", 1, 0);
        end else begin
          e = txq.pop_front();
          b9 = 1'b0;
          if (e[9]) begin
            repeat (BT) @(negedge clk);
            b9 = txd;
          end
          repeat (BT) @(negedge clk);
          sp = txd;
          check("R2 tx start bit", st, 0);
          check("R2 tx data", d, e[7:0]);
          if (e[9]) check("R2 tx ninth bit", b9, e[8]);
          check("R2 tx stop bit", sp, 1);
        end
      end
    end
  end

  task automatic tx_case(logic [7:0] d, logic m9, logic b8);
    logic [7:0] c;
    tx_send(d, m9, b8);
    repeat (100) @(negedge clk);
    rd(1'b0, c);
    check("R3 TI low mid-frame", c[0], 0);
    repeat ((m9 ? 11 : 10) * BT) @(negedge clk);
    rd(1'b0, c);
    check("R3 TI set after stop", c[0], 1);
    check("R8 irq with TI", irq, 1);
  endtask

  task automatic rx_case(logic [7:0] d, logic m9, logic b8, int gbit, string tag);
    logic [7:0] c, v;
    rxq.push_back(d);
    rx_frame(d, m9, b8, gbit);
    rd(1'b0, c);
    check({tag, " RI set"}, c[1], 1);
    check({tag, " RB8"}, c[3], m9 ? b8 : 1'b1);
    rd(1'b1, v);
    check({tag, " data"}, v, rxq.pop_front());
  endtask

  initial begin : main
    logic [7:0] c, v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 txd idle", txd, 1);
    check("R1 irq", irq, 0);
    rd(1'b0, c); check("R1 control", c, 8'h00);
    rd(1'b1, v); check("R1 data", v, 8'h00);

    wr(1'b0, 8'h27);
    tx_case(8'hA5, 0, 0);
    repeat (200) @(negedge clk);
    rd(1'b0, c); check("R7 TI still set", c[0], 1);
    wr(1'b0, 8'h26);
    rd(1'b0, c); check("R7 TI cleared by write", c[0], 0);
    check("R8 irq low", irq, 0);
    tx_case(8'h00, 0, 0); wr(1'b0, 8'h26);
    tx_case(8'hFF, 0, 0); wr(1'b0, 8'h26);
    tx_case(8'h80, 0, 0); wr(1'b0, 8'h26);
    rd(1'b1, v); check("R4 data read not tx", v, 8'h00);

    rx_case(8'h3C, 0, 0, -1, "R6 rx 8-bit");
    check("R8 irq with RI", irq, 1);
    rd(1'b0, c); check("R9 no overrun yet", c[2], 0);
    wr(1'b0, 8'h25);
    rd(1'b0, c); check("R7 RI cleared", c[1], 0);
    rx_case(8'h96, 0, 0, 3, "R5 majority glitch");

    rxq.push_back(8'h5A);
    fork
      rx_frame(8'h5A, 0, 0, -1);
      begin
        repeat (5 * BT) @(negedge clk);
        rd(1'b1, v); check("R9 latch held during next frame", v, 8'h96);
      end
    join
    rd(1'b1, v); check("R9 overwrite", v, rxq.pop_front());
    rd(1'b0, c); check("R9 OVR set", c[2], 1);
    wr(1'b0, 8'h20);
    rd(1'b0, c); check("R7 flags cleared", c[2:0], 0);

    wr(1'b0, 8'h70);
    tx_case(8'hC3, 1, 1);
    wr(1'b0, 8'h60);
    tx_case(8'h81, 1, 0);
    wr(1'b0, 8'h60);
    rd(1'b1, v); check("R4 data read after tx", v, 8'h5A);

    rx_case(8'h7E, 1, 0, -1, "R6 rx 9-bit b8=0");
    wr(1'b0, 8'h60);
    rx_case(8'h01, 1, 1, -1, "R6 rx 9-bit b8=1");
    wr(1'b0, 8'h60);

    @(negedge clk); rxd = 1'b0;
    repeat (12) @(negedge clk); rxd = 1'b1;
    repeat (12 * BT) @(negedge clk);
    rd(1'b0, c); check("R5 false start rejected", c[1], 0);

    wr(1'b0, 8'h40);
    rx_frame(8'hAA, 1, 0, -1);
    rd(1'b0, c); check("R10 RI stays low", c[1], 0);
    rd(1'b1, v); check("R10 latch unchanged", v, 8'h01);

    repeat (100) @(negedge clk);
    check("R2 all tx frames seen", txq.size(), 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule